// File: doc/BRIEF.md
# Oscillator Stabilization Timer Divider

This block is a long binary divider with two jobs. When an external oscillator is switched on, the divider works as a startup timer. It counts edges of the external clock until a programmed number of cycles has passed, and only then does it declare the oscillator stable. After that point it becomes an ordinary reference divider. It then counts edges of the internal base clock and emits one tick at the end of every full count.

The whole block runs on one system clock. Edges of the external clock and of the internal base clock arrive as one-cycle qualified tick-enable inputs. The other inputs are:

- the external generator enable;
- a select between a short (16) and a long (4096) count;
- a clock-loss indication from a separate activity monitor.

The stable flag is sticky. Only two things clear it: dropping the enable, or a reported clock loss. Either one sends the divider back to startup timing from a count of zero.

Top module: `osc_stab_divider`

## Requirements
- R1: While `ext_en` is low (and in reset), `stable` is 0, `div_tick` is 0 and the internal count is held at zero.
- R2: While `stable` is 0 the count advances only on `ext_tick`; `base_tick` has no effect on when `stable` sets.
- R3: With the short length selected (`len_long` = 0), `stable` reads 1 in the cycle after the 16th `ext_tick` counted since entering startup timing, and not earlier.
- R4: With the long length selected (`len_long` = 1), the startup time is 4096 `ext_tick` pulses, and in normal mode `div_tick` pulses once per 4096 `base_tick` pulses.
- R5: The length is taken from `len_long` in the cycle in which `ext_en` rises (0 = 16, 1 = 4096). Later changes of `len_long` while `ext_en` stays high have no effect.
- R6: While `stable` is 1 the count advances only on `base_tick`. `div_tick` is a one-cycle pulse in the cycle after every N-th `base_tick`, where N is the selected length. `ext_tick` has no effect in this mode.
- R7: `div_tick` is never 1 while the divider is in startup timing.
- R8: Once set, `stable` stays 1 through any number of normal-mode wraps for as long as `ext_en` is high and `clk_lost` is low.
- R9: A `clk_lost` pulse clears `stable` in the next cycle and restarts startup timing from zero, so a further full N `ext_tick` pulses are needed.
- R10: When `clk_lost` and the completing `ext_tick` arrive in the same cycle, the loss wins: `stable` stays 0 and the count restarts from zero.
- R11: Dropping and raising `ext_en` discards any partial startup count; timing restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | External generator enable |
| ext_tick | input | 1 | One-cycle pulse per external clock edge |
| base_tick | input | 1 | One-cycle pulse per internal base clock edge |
| len_long | input | 1 | Length select: 0 = 16 counts, 1 = 4096 counts |
| clk_lost | input | 1 | External clock reported inactive by the monitor |
| stable | output | 1 | Sticky external-oscillator-stable flag |
| div_tick | output | 1 | One-cycle divided reference tick |

## Verification
Most wrong internal states show up at the ports within one count period.

- **Count off by one or wrong length latched.** `stable` rises one or more cycles early or late. With the long length, this becomes visible only after 4096 ticks.
- **Count not cleared on loss or re-enable.** This shows as an early `stable` within 16 ticks of the restart.
- **Mode steered to the wrong tick source.** `div_tick` then appears during startup timing, or follows external rather than base ticks, on the first wrap.

The bench compares both outputs every cycle against a model, so any of these is caught in the first cycle in which it differs.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;

   typedef enum logic {
      MODE_STARTUP = 1'b0,
      MODE_NORMAL  = 1'b1
   } div_mode_e;

   // terminal count for a length field of the given width
   function automatic logic [31:0] field_limit(input int unsigned width);
      return (32'd1 << width) - 32'd1;
   endfunction

endpackage

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl
   import osc_stab_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ext_en,
   input  logic      len_long,
   input  logic      clk_lost,
   input  logic      startup_done,
   output logic      stable,
   output div_mode_e mode,
   output logic      len_eff,
   output logic      cnt_clear
);

   logic en_d;
   logic len_q;
   logic en_rise;

   assign en_rise   = ext_en & ~en_d;
   assign len_eff   = en_rise ? len_long : len_q;
   assign cnt_clear = ~ext_en | clk_lost;
   assign mode      = stable ? MODE_NORMAL : MODE_STARTUP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d  <= 1'b0;
         len_q <= 1'b0;
      end else begin
         en_d <= ext_en;
         if (en_rise) begin
            len_q <= len_long;
         end
      end
   end

   // loss and disable take priority over completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stable <= 1'b0;
      end else if (cnt_clear) begin
         stable <= 1'b0;
      end else if (startup_done) begin
         stable <= 1'b1;
      end
   end

   a_r5_len_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (ext_en && en_d) |=> (len_q == $past(len_q)));

   a_r10_loss_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_lost && startup_done) |=> !stable);

   a_r8_flag_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (stable && ext_en && !clk_lost) |=> stable);

endmodule

// File: rtl/osc_stab_counter.sv
module osc_stab_counter
   import osc_stab_pkg::*;
#(
   parameter int unsigned LONG_W      = 12,
   parameter int unsigned SHORT_W     = 4,
   parameter bit          WRAP_BY_MSB = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear,
   input  div_mode_e mode,
   input  logic      len_eff,
   input  logic      ext_tick,
   input  logic      base_tick,
   output logic      startup_done,
   output logic      div_tick
);

   localparam int unsigned CNT_W = LONG_W;
   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(field_limit(SHORT_W));
   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(field_limit(LONG_W));

   initial begin : p_param_chk
      assert (SHORT_W >= 1 && SHORT_W < LONG_W && LONG_W <= 31)
         else $error("osc_stab_counter: SHORT_W must be 1..LONG_W-1, LONG_W <= 31");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] lim;
   logic             step;
   logic             wrap;

   assign lim     = len_eff ? LIM_LONG : LIM_SHORT;
   assign step    = (mode == MODE_STARTUP) ? ext_tick : base_tick;
   assign cnt_inc = (cnt + CNT_W'(1)) & lim;

   generate
      if (WRAP_BY_MSB) begin : g_wrap_msb
         // wrap seen as the field MSB falling from 1 to 0
         logic msb_now;
         logic msb_nxt;
         assign msb_now = len_eff ? cnt[LONG_W-1]     : cnt[SHORT_W-1];
         assign msb_nxt = len_eff ? cnt_inc[LONG_W-1] : cnt_inc[SHORT_W-1];
         assign wrap    = step & msb_now & ~msb_nxt;
      end else begin : g_wrap_cmp
         assign wrap = step & (cnt == lim);
      end
   endgenerate

   assign startup_done = (mode == MODE_STARTUP) & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_tick <= 1'b0;
      end else begin
         div_tick <= (mode == MODE_NORMAL) & wrap & ~clear;
      end
   end

   a_r1_held_clear : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

   a_r6_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      div_tick |=> !div_tick);

   a_r7_no_tick_startup : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STARTUP) |=> !div_tick);

endmodule

// File: rtl/osc_stab_divider.sv
module osc_stab_divider
   import osc_stab_pkg::*;
#(
   parameter int unsigned LONG_W      = 12,
   parameter int unsigned SHORT_W     = 4,
   parameter bit          WRAP_BY_MSB = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_en,
   input  logic ext_tick,
   input  logic base_tick,
   input  logic len_long,
   input  logic clk_lost,
   output logic stable,
   output logic div_tick
);

   div_mode_e mode;
   logic      len_eff;
   logic      cnt_clear;
   logic      startup_done;

   osc_stab_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_en       (ext_en),
      .len_long     (len_long),
      .clk_lost     (clk_lost),
      .startup_done (startup_done),
      .stable       (stable),
      .mode         (mode),
      .len_eff      (len_eff),
      .cnt_clear    (cnt_clear)
   );

   osc_stab_counter #(
      .LONG_W      (LONG_W),
      .SHORT_W     (SHORT_W),
      .WRAP_BY_MSB (WRAP_BY_MSB)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (cnt_clear),
      .mode         (mode),
      .len_eff      (len_eff),
      .ext_tick     (ext_tick),
      .base_tick    (base_tick),
      .startup_done (startup_done),
      .div_tick     (div_tick)
   );

   a_r1_off_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !ext_en |=> (!stable && !div_tick));

   a_r2_set_by_ext : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable) |-> $past(ext_tick));

   a_r9_loss_clears : assert property (@(posedge clk) disable iff (!rst_n)
      clk_lost |=> !stable);

endmodule

// File: tb/osc_stab_divider_test.sv
`timescale 1ns/1ps
module osc_stab_divider_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_en = 1'b0;
   logic ext_tick = 1'b0;
   logic base_tick = 1'b0;
   logic len_long = 1'b0;
   logic clk_lost = 1'b0;
   logic stable;
   logic div_tick;

   always #5 clk = ~clk;

   osc_stab_divider uut (
      .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .ext_tick(ext_tick),
      .base_tick(base_tick), .len_long(len_long), .clk_lost(clk_lost),
      .stable(stable), .div_tick(div_tick)
   );

   typedef struct {
      bit    exp_stable;
      bit    exp_tick;
      string req;
   } exp_item_t;

   exp_item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference state derived from the requirements
   int m_cnt = 0;
   bit m_stable = 1'b0;
   bit m_len = 1'b0;
   bit m_en_d = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic step(input bit en, input bit et, input bit bt, input bit ls,
                       input bit lost, input string req);
      exp_item_t it;
      bit tick;
      int n;
      @(negedge clk);
      ext_en = en; ext_tick = et; base_tick = bt; len_long = ls; clk_lost = lost;
      tick = 1'b0;
      if (!en) begin
         m_cnt = 0; m_stable = 1'b0;
      end else begin
         if (!m_en_d) m_len = ls;
         n = m_len ? 4096 : 16;
         if (lost) begin
            m_cnt = 0; m_stable = 1'b0;
         end else if (!m_stable) begin
            if (et) begin
               if (m_cnt == n - 1) begin m_cnt = 0; m_stable = 1'b1; end
               else m_cnt++;
            end
         end else if (bt) begin
            if (m_cnt == n - 1) begin m_cnt = 0; tick = 1'b1; end
            else m_cnt++;
         end
      end
      m_en_d = en;
      it.exp_stable = m_stable;
      it.exp_tick = tick;
      it.req = req;
      sb_q.push_back(it);
   endtask

   // monitor: compares after the edge that consumed the stimulus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            chk(stable == it.exp_stable, {it.req, " stable"}, int'(stable), int'(it.exp_stable));
            chk(div_tick == it.exp_tick, {it.req, " div_tick"}, int'(div_tick), int'(it.exp_tick));
         end
      end
   end

   task automatic run(input int cycles, input bit en, input bit et, input bit bt,
                      input bit ls, input string req);
      for (int i = 0; i < cycles; i++) step(en, et, bt, ls, 1'b0, req);
   endtask

   task automatic drain();
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(stable == 1'b0, "R1 reset stable", int'(stable), 0);
      chk(div_tick == 1'b0, "R1 reset div_tick", int'(div_tick), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: disabled, ticks arriving
      run(40, 1'b0, 1'b1, 1'b1, 1'b0, "R1");

      // R2: enabled, short length, only base ticks
      run(30, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
      // R3: 16 external ticks every other cycle
      for (int i = 0; i < 16; i++) begin
         step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
         step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      end
      drain();
      chk(stable == 1'b1, "R3 set after 16", int'(stable), 1);

      // R6/R8: normal division, external ticks ignored
      run(50, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
      run(40, 1'b1, 1'b0, 1'b1, 1'b0, "R8");

      // R9: loss, then restart from zero; R7: base ticks give no div_tick
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
      run(15, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
      drain();
      chk(stable == 1'b0, "R9 not yet after 15", int'(stable), 0);
      run(1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
      drain();
      chk(stable == 1'b1, "R9 set after 16", int'(stable), 1);

      // R10: loss coinciding with the completing tick
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
      run(15, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R10");
      drain();
      chk(stable == 1'b0, "R10 loss wins", int'(stable), 0);
      run(16, 1'b1, 1'b1, 1'b0, 1'b0, "R10");

      // R11: partial count discarded on re-enable
      run(2, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      run(10, 1'b1, 1'b1, 1'b0, 1'b0, "R11");
      run(2, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      run(15, 1'b1, 1'b1, 1'b0, 1'b0, "R11");
      drain();
      chk(stable == 1'b0, "R11 restart from zero", int'(stable), 0);
      run(1, 1'b1, 1'b1, 1'b0, 1'b0, "R11");

      // R5: long sampled in rise cycle, later select changes ignored
      run(2, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
      run(40, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
      drain();
      chk(stable == 1'b0, "R5 long kept", int'(stable), 0);
      // R4: complete the 4096 startup, then one long division
      run(4096 - 41, 1'b1, 1'b1, 1'b0, 1'b1, "R4");
      drain();
      chk(stable == 1'b1, "R4 set after 4096", int'(stable), 1);
      run(4096, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
      run(20, 1'b1, 1'b0, 1'b1, 1'b0, "R4");

      drain();
      drain();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule